// File: doc/BRIEF.md
# Command-Driven Sync Timing Sequencer

This block generates the horizontal and vertical sync waveforms of a video raster from a stream of 32-bit timing words. A producer offers words on a valid/ready handshake. Each word sets both sync levels, carries a period count, and carries a 16-bit side command that can raise a one-cycle interrupt. A word is taken, its levels drive the sync outputs, its command runs, and the block then waits out the period before it asks for the next word.

Every period costs a fixed overhead of five clocks on top of the count. A period of N clocks is therefore coded as N - 5. Software places the interrupt by pulling the back-porch word earlier and stretching the active-video word by the same amount. The line length stays the same and the interrupt arrives ahead of active video. If no word is waiting when one is due, the block holds its sync levels and stalls until a word arrives.

Top module: `sync_timing_seq`

## Requirements
- R1: A timing word holds the H-sync level in bit 0, the V-sync level in bit 1, a 14-bit period count in bits 15:2 and a 16-bit command in bits 31:16.
- R2: A word's sync levels appear on `hsyncOut`/`vsyncOut` in the cycle after its handshake. They do not change again until the next handshake.
- R3: A word's levels are held for exactly count + 5 cycles when the next word is already offered: count 0 gives 5 cycles, count 1 gives 6, and count 16383 gives 16388.
- R4: `wordReady` is low from the cycle after a handshake until the last cycle of that period, when it rises again. One word is taken per period.
- R5: Command value 16'h0001 drives `irqOut` high for exactly one cycle, the second cycle of the period. Command 16'h0000 and every other value produce no pulse. The command never changes the period length.
- R6: While no word is offered in the fetch state, the sync levels hold, `wordReady` stays high and `irqOut` stays low. The next word still gets its full count + 5 cycles, counted from its own handshake.
- R7: A synchronous active-high `rst` abandons any period in progress. In the following cycle `hsyncOut` and `vsyncOut` are 1, `irqOut` is 0 and `wordReady` is 1.
- R8: Words offered back to back produce periods with no gap cycles between them. A sequence of periods therefore lasts the sum of its (count + 5) lengths, and shifting 10 clocks from one word to its neighbour leaves the total unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wordValid | input | 1 | A timing word is offered |
| wordData | input | 32 | Timing word (layout in R1) |
| wordReady | output | 1 | Block takes the offered word this cycle |
| hsyncOut | output | 1 | Horizontal sync level |
| vsyncOut | output | 1 | Vertical sync level |
| irqOut | output | 1 | One-cycle interrupt pulse from the command |

## Verification
The hardest case to reach is an underrun that ends exactly when the block becomes ready. The bench must show that the stall stretches the old levels without cutting into the new period. To get there, the stimulus lets the longest period run out with no word queued and watches the held levels over several idle cycles. It then offers a short word that carries the interrupt command and times that word from its own handshake. A reset in the middle of a long period is also driven, to show that the wait loop is abandoned rather than finished.

// File: rtl/sync_timing_pkg.sv
package sync_timing_pkg;

  localparam int SYNC_PINS = 2;
  localparam int FIXED_OVERHEAD = 5;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LOAD,
    ST_CMD_A,
    ST_CMD_B,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic takeWord;
    logic loadCount;
    logic armCmd;
    logic stepCount;
  } seqStrobe_t;

endpackage

// File: rtl/sync_timing_ctrl.sv
module sync_timing_ctrl
  import sync_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wordValid,
  input  logic       countZero,
  output logic       wordReady,
  output seqStrobe_t strobe
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_FETCH: begin
        if (wordValid) begin
          strobe.takeWord = 1'b1;
          nextState       = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strobe.loadCount = 1'b1;
        strobe.armCmd    = 1'b1;
        nextState        = ST_CMD_A;
      end
      ST_CMD_A: nextState = ST_CMD_B;
      ST_CMD_B: nextState = ST_WAIT;
      ST_WAIT: begin
        if (countZero) nextState = ST_FETCH;
        else           strobe.stepCount = 1'b1;
      end
      default: nextState = ST_FETCH;
    endcase
  end

  assign wordReady = (state == ST_FETCH);

endmodule

// File: rtl/sync_timing_dp.sv
module sync_timing_dp
  import sync_timing_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CMD_W   = 16,
  parameter logic [CMD_W-1:0] IRQ_CMD = 1,
  localparam int WORD_W = SYNC_PINS + CNT_W + CMD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqStrobe_t           strobe,
  input  logic [WORD_W-1:0]    wordData,
  output logic [SYNC_PINS-1:0] syncLevels,
  output logic                 irqOut,
  output logic                 countZero
);

  localparam int CNT_LSB = SYNC_PINS;
  localparam int CMD_LSB = SYNC_PINS + CNT_W;

  logic [CNT_W-1:0] heldCount;
  logic [CMD_W-1:0] heldCmd;
  logic [CNT_W-1:0] waitCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncLevels <= '1;
      heldCount  <= '0;
      heldCmd    <= '0;
    end else if (strobe.takeWord) begin
      syncLevels <= wordData[SYNC_PINS-1:0];
      heldCount  <= wordData[CNT_LSB +: CNT_W];
      heldCmd    <= wordData[CMD_LSB +: CMD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   waitCount <= '0;
    else if (strobe.loadCount) waitCount <= heldCount;
    else if (strobe.stepCount) waitCount <= waitCount - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irqOut <= 1'b0;
    else     irqOut <= strobe.armCmd && (heldCmd == IRQ_CMD);
  end

  assign countZero = (waitCount == '0);

endmodule

// File: rtl/sync_timing_seq.sv
module sync_timing_seq
  import sync_timing_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CMD_W   = 16,
  parameter logic [CMD_W-1:0] IRQ_CMD = 1,
  localparam int WORD_W = SYNC_PINS + CNT_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              irqOut
);

  seqStrobe_t           strobe;
  logic                 countZero;
  logic [SYNC_PINS-1:0] syncLevels;

  sync_timing_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wordValid (wordValid),
    .countZero (countZero),
    .wordReady (wordReady),
    .strobe    (strobe)
  );

  sync_timing_dp #(
    .CNT_W   (CNT_W),
    .CMD_W   (CMD_W),
    .IRQ_CMD (IRQ_CMD)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wordData   (wordData),
    .syncLevels (syncLevels),
    .irqOut     (irqOut),
    .countZero  (countZero)
  );

  assign hsyncOut = syncLevels[0];
  assign vsyncOut = syncLevels[1];

endmodule

// File: rtl/sync_timing_seq_chk.sv
module sync_timing_seq_chk #(
  parameter int CNT_W  = 14,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordData,
  input logic              wordReady,
  input logic              hsyncOut,
  input logic              vsyncOut,
  input logic              irqOut
);

  localparam int LEN_W = CNT_W + 3;

  logic             accept;
  logic [LEN_W-1:0] gapCnt;
  logic [LEN_W-1:0] expectLen;
  logic             seenWord;

  assign accept = wordValid && wordReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt    <= '0;
      expectLen <= '0;
      seenWord  <= 1'b0;
    end else if (accept) begin
      gapCnt    <= LEN_W'(1);
      expectLen <= LEN_W'(wordData[2 +: CNT_W]) + LEN_W'(5);
      seenWord  <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> (hsyncOut && vsyncOut && !irqOut && wordReady));

  assert_levels_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable({hsyncOut, vsyncOut}));

  assert_period_len_R3: assert property (@(posedge clk) disable iff (rst)
    (seenWord && $rose(wordReady)) |-> (gapCnt == expectLen));

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> !wordReady);

  assert_ready_low_span_R4: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##4 !wordReady);

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    irqOut |=> !irqOut);

  assert_irq_place_R5: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> $past(accept, 2));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wordReady && !wordValid) |=> (wordReady && !irqOut && $stable({hsyncOut, vsyncOut})));

endmodule

bind sync_timing_seq sync_timing_seq_chk #(
  .CNT_W  (CNT_W),
  .WORD_W (WORD_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .wordValid (wordValid),
  .wordData  (wordData),
  .wordReady (wordReady),
  .hsyncOut  (hsyncOut),
  .vsyncOut  (vsyncOut),
  .irqOut    (irqOut)
);

// File: tb/test_sync_timing_seq.sv
`timescale 1ns/1ps
module test_sync_timing_seq;

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] expLen;
    logic        expIrq;
  } vec_t;

  function automatic logic [31:0] mkWord(input logic hs, input logic vs,
                                         input int cnt, input logic [15:0] cmd);
    logic [13:0] c;
    c = cnt[13:0];
    return {cmd, c, vs, hs};
  endfunction

  // R1 layout: bit0 hsync, bit1 vsync, 15:2 count, 31:16 command
  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{mkWord(1'b0, 1'b1, 0,     16'h0000), 32'd5,     1'b0},
    '{mkWord(1'b1, 1'b0, 1,     16'h0001), 32'd6,     1'b1},
    '{mkWord(1'b0, 1'b0, 37,    16'h0002), 32'd42,    1'b0},
    '{mkWord(1'b1, 1'b1, 11,    16'h0000), 32'd16,    1'b0},
    '{mkWord(1'b0, 1'b1, 19,    16'h0000), 32'd24,    1'b0},
    '{mkWord(1'b1, 1'b1, 25,    16'h0000), 32'd30,    1'b0},
    '{mkWord(1'b1, 1'b1, 165,   16'h0001), 32'd170,   1'b1},
    '{mkWord(1'b0, 1'b0, 16383, 16'h8001), 32'd16388, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordReady, hsyncOut, vsyncOut, irqOut;

  int nChecks = 0;
  int nErr = 0;
  int cycleCnt = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  sync_timing_seq i_sync_timing_seq (
    .clk       (clk),
    .rst       (rst),
    .wordValid (wordValid),
    .wordData  (wordData),
    .wordReady (wordReady),
    .hsyncOut  (hsyncOut),
    .vsyncOut  (vsyncOut),
    .irqOut    (irqOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Starts at a negedge with wordReady high; ends at the negedge of the last period cycle.
  task automatic runWord(input logic [31:0] w, input int expLen, input logic expIrq,
                         input string tag);
    int lvK, irqK, rdyK;
    int lvAct, irqAct, rdyAct;
    lvK = 0; irqK = 0; rdyK = 0; lvAct = 0; irqAct = 0; rdyAct = 0;
    wordValid = 1'b1;
    wordData  = w;
    @(negedge clk);
    wordValid = 1'b0;
    wordData  = '0;
    for (int k = 1; k <= expLen; k++) begin
      if (lvK == 0 && {vsyncOut, hsyncOut} != w[1:0]) begin
        lvK = k; lvAct = int'({vsyncOut, hsyncOut});
      end
      if (irqK == 0 && irqOut != (expIrq && k == 2)) begin
        irqK = k; irqAct = int'(irqOut);
      end
      if (rdyK == 0 && wordReady != (k == expLen)) begin
        rdyK = k; rdyAct = int'(wordReady);
      end
      if (k < expLen) @(negedge clk);
    end
    check(lvK == 0, "R1 R2", {tag, " levels {v,h} (first bad cycle in log)"},
          lvAct, int'(w[1:0]));
    if (lvK != 0) $display("  levels mismatch at period cycle %0d", lvK);
    check(irqK == 0, "R5", {tag, " irq at mismatching cycle"}, irqAct,
          int'(expIrq && irqK == 2));
    if (irqK != 0) $display("  irq mismatch at period cycle %0d", irqK);
    check(rdyK == 0, "R3 R4", {tag, " ready/period length, bad cycle"}, rdyK, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int stampA, stampB;
    int bad;
    // R7: reset state
    repeat (3) @(negedge clk);
    check(hsyncOut && vsyncOut && !irqOut && wordReady, "R7", "idle under reset {h,v,irq,rdy}",
          int'({hsyncOut, vsyncOut, irqOut, wordReady}), 4'b1101);
    rst = 1'b0;
    @(negedge clk);
    check(hsyncOut && vsyncOut && wordReady && !irqOut, "R6", "idle with no word {h,v,irq,rdy}",
          int'({hsyncOut, vsyncOut, irqOut, wordReady}), 4'b1101);

    // table walk, words back to back (R8)
    stampA = 0;
    for (int i = 0; i < NVEC; i++) begin
      if (i == 3) stampA = cycleCnt;
      if (i == 7) begin
        stampB = cycleCnt;
        check(stampB - stampA == 240, "R8", "scanline total of four periods",
              stampB - stampA, 240);
      end
      runWord(VEC[i].word, int'(VEC[i].expLen), VEC[i].expIrq, $sformatf("vec%0d", i));
    end

    // R6: underrun after last word, levels of vec7 (0,0) hold
    bad = 0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (hsyncOut || vsyncOut || irqOut || !wordReady) bad++;
    end
    check(bad == 0, "R6", "stall cycles with wrong outputs", bad, 0);
    runWord(mkWord(1'b1, 1'b0, 3, 16'h0001), 8, 1'b1, "R6 word after stall");

    // R7: reset mid-period
    wordValid = 1'b1;
    wordData  = mkWord(1'b1, 1'b0, 40, 16'h0000);
    @(negedge clk);
    wordValid = 1'b0;
    repeat (10) @(negedge clk);
    check(hsyncOut && !vsyncOut && !wordReady, "R2", "mid-period {h,v,rdy}",
          int'({hsyncOut, vsyncOut, wordReady}), 3'b100);
    rst = 1'b1;
    @(negedge clk);
    check(hsyncOut && vsyncOut && !irqOut && wordReady, "R7", "after mid-period reset {h,v,irq,rdy}",
          int'({hsyncOut, vsyncOut, irqOut, wordReady}), 4'b1101);
    rst = 1'b0;
    @(negedge clk);
    runWord(mkWord(1'b0, 1'b1, 2, 16'h0000), 7, 1'b0, "R7 restart");
    runWord(mkWord(1'b1, 1'b0, 0, 16'h0001), 5, 1'b1, "R5 irq on shortest");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule